// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block runs the digital side of a ramp-type converter, in which an input voltage is turned into a time interval and then into a count. A slow, active-low trigger pulse starts each conversion. The sequencer first zeroes a two-digit decimal counter. It then opens a counting window: the external ramp integrator is released, and each count-enable tick advances the counter. When the external comparator falls, the ramp has crossed the input voltage. That edge closes the window, holds the ramp at zero again and latches the count into a result register.

The trigger and comparator come from slow or analog sources, so both are brought into the system clock domain before use. A count that reaches 99 before the comparator trips stays at 99, and an overflow flag is raised with the result. The result register keeps its value until the next conversion ends, so a display driven from it does not flicker while a new measurement is in progress. The tick rate is set outside the block so that a count of 100 would stand for a 10 V input.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, busy is 0, ramp_hold is 1, both result digits are 0 and res_ovf is 0.
- R2: A high-to-low transition on trig_n seen while idle starts a conversion, and busy goes to 1.
- R3: ramp_hold is 0 only during the counting window and is 1 whenever busy is 0.
- R4: The counter is zeroed before the counting window opens. Ticks that arrive between the trigger and the opening of the window are not counted, and ramp_hold is still 1 in the cycle where busy rises.
- R5: Each cycle with tick high inside the window adds one to the count in decimal order. The count is two BCD digits: res_units holds 0 to 9, res_tens holds 0 to 9, and the value is tens*10+units.
- R6: A high-to-low transition on cmp ends the window. busy returns to 0 and the count is copied to res_tens/res_units. A tick in the same cycle as the detected edge is not counted.
- R7: One low pulse on cmp, whatever its length, is one stop event. A cmp pulse while idle has no effect on busy or on the result.
- R8: If a tick arrives while the count is 99, the count stays at 99 and the overflow is reported as res_ovf=1 with that result.
- R9: A trigger edge during a conversion is ignored. The count is not cleared and the window stays open.
- R10: res_tens, res_units and res_ovf do not change while busy is 1.
- R11: res_ovf is 0 in the result of any conversion whose count did not pass 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| trig_n | input | 1 | Active-low conversion trigger, asynchronous |
| tick | input | 1 | Count-enable tick, one system-clock cycle wide |
| cmp | input | 1 | Comparator level, falls when the ramp passes the input, asynchronous |
| ramp_hold | output | 1 | 1 holds the ramp integrator at zero, 0 lets it rise |
| res_tens | output | 4 | Latched tens digit, BCD |
| res_units | output | 4 | Latched units digit, BCD |
| res_ovf | output | 1 | Latched overflow flag, the count passed 99 |
| busy | output | 1 | A conversion is in progress |

## Verification
The stop edge and a counting tick can fall in the same clock cycle. In that case the stop must win, and the tick must not reach the latched count. The bench provokes this by timing a tick to arrive in exactly the cycle in which the synchronised comparator fall is seen, and a separate run puts a tick one cycle earlier. The scoreboard expects the count without the colliding tick and with the earlier one. A second collision, a trigger arriving in mid-count, is judged by the result still equalling the full number of ticks given.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_n,
  input  logic       tick,
  input  logic       cmp,
  output logic       ramp_hold,
  output logic [3:0] res_tens,
  output logic [3:0] res_units,
  output logic       res_ovf,
  output logic       busy
);

  typedef enum logic [1:0] {IDLE, CLEAR, ARM, RUN} state_t;

  state_t               state;
  logic [SYNC_STAGES:0] trig_sh, cmp_sh;
  logic [3:0]           cnt_tens, cnt_units;
  logic                 cnt_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_sh <= '1;
      cmp_sh  <= '1;
    end else begin
      trig_sh <= {trig_sh[SYNC_STAGES-1:0], trig_n};
      cmp_sh  <= {cmp_sh[SYNC_STAGES-1:0], cmp};
    end
  end

  wire trig_fall = trig_sh[SYNC_STAGES] & ~trig_sh[SYNC_STAGES-1];
  wire cmp_fall  = cmp_sh[SYNC_STAGES]  & ~cmp_sh[SYNC_STAGES-1];
  wire at_max    = (cnt_tens == 4'd9) && (cnt_units == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt_tens  <= '0;
      cnt_units <= '0;
      cnt_ovf   <= 1'b0;
      res_tens  <= '0;
      res_units <= '0;
      res_ovf   <= 1'b0;
    end else begin
      case (state)
        IDLE:  if (trig_fall) state <= CLEAR;
        CLEAR: begin
          cnt_tens  <= '0;
          cnt_units <= '0;
          cnt_ovf   <= 1'b0;
          state     <= ARM;
        end
        ARM:   state <= RUN;
        RUN: begin
          if (cmp_fall) begin
            state     <= IDLE;
            res_tens  <= cnt_tens;
            res_units <= cnt_units;
            res_ovf   <= cnt_ovf;
          end else if (tick) begin
            if (at_max) cnt_ovf <= 1'b1;
            else if (cnt_units == 4'd9) begin
              cnt_units <= '0;
              cnt_tens  <= cnt_tens + 4'd1;
            end else cnt_units <= cnt_units + 4'd1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy      = (state != IDLE);
  assign ramp_hold = (state != RUN);

  AST_HOLD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ramp_hold); // R4
  AST_CLEAR_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARM) |=> (cnt_tens == 4'd0 && cnt_units == 4'd0 && !cnt_ovf)); // R4
  AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_units <= 4'd9) && (cnt_tens <= 4'd9)); // R5
  AST_STOP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && cmp_fall) |=> (!busy && res_tens == $past(cnt_tens)
                                    && res_units == $past(cnt_units))); // R6
  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && at_max && !cmp_fall) |=> (cnt_tens == 4'd9 && cnt_units == 4'd9)); // R8
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && trig_fall && !cmp_fall) |=> (state == RUN)); // R9
  AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($stable(res_tens) && $stable(res_units) && $stable(res_ovf))); // R10

endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, trig_n = 1'b1, tick = 1'b0, cmp = 1'b1;
  logic ramp_hold, res_ovf, busy;
  logic [3:0] res_tens, res_units;

  int errors = 0, checks = 0;
  int exp_q[$];
  string tag_q[$];
  int last_val = 0;
  logic prev_busy = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ramp_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .tick(tick), .cmp(cmp),
    .ramp_hold(ramp_hold), .res_tens(res_tens), .res_units(res_units),
    .res_ovf(res_ovf), .busy(busy)
  );

  function automatic int res_code();
    return int'(res_ovf) * 1000 + int'(res_tens) * 10 + int'(res_units);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && prev_busy && !busy) begin
      if (exp_q.size() == 0) check("R6 unexpected end of conversion", 1, 0);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, res_code(), e);
        last_val = e;
      end
    end
    prev_busy = busy;
  end

  task automatic start_trig();
    @(negedge clk) trig_n = 1'b0;
    repeat (3) @(negedge clk);
    trig_n = 1'b1;
    check("R2 busy after trigger", int'(busy), 1);
    check("R4 ramp held in clear", int'(ramp_hold), 1);
  endtask

  task automatic wait_run();
    while (ramp_hold) @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic expect_res(input int n, input string tag);
    exp_q.push_back(n > 99 ? 1099 : n);
    tag_q.push_back(tag);
  endtask

  task automatic stop(input bit colliding_tick, input int low_cycles);
    @(negedge clk) cmp = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) tick = colliding_tick;
    @(negedge clk) tick = 1'b0;
    repeat (low_cycles) @(negedge clk);
    cmp = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic convert(input int n, input string tag);
    start_trig();
    wait_run();
    check("R3 ramp released in window", int'(ramp_hold), 0);
    check("R10 result stable while busy", res_code(), last_val);
    give_ticks(n);
    expect_res(n, tag);
    stop(1'b0, 3);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 ramp_hold after reset", int'(ramp_hold), 1);
    check("R1 result after reset", res_code(), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    convert(7, "R5 R6 count of 7");
    check("R3 ramp held when idle", int'(ramp_hold), 1);
    convert(57, "R5 R11 count of 57 across tens");
    convert(120, "R8 saturation at 99");
    convert(0, "R11 zero count clears overflow");

    start_trig();
    wait_run();
    give_ticks(13);
    expect_res(14, "R6 tick one cycle before stop counts");
    @(negedge clk) cmp = 1'b0;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
    cmp = 1'b1;
    repeat (6) @(negedge clk);

    start_trig();
    wait_run();
    give_ticks(22);
    expect_res(22, "R6 colliding tick dropped");
    stop(1'b1, 2);

    start_trig();
    wait_run();
    give_ticks(30);
    @(negedge clk) trig_n = 1'b0;
    repeat (4) @(negedge clk);
    trig_n = 1'b1;
    check("R9 window open after mid trigger", int'(ramp_hold), 0);
    give_ticks(11);
    expect_res(41, "R9 mid trigger ignored");
    stop(1'b0, 20);

    @(negedge clk) cmp = 1'b0;
    @(negedge clk) cmp = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 idle comparator pulse busy", int'(busy), 0);
    check("R7 idle comparator pulse result", res_code(), 41);

    @(negedge clk) tick = 1'b1;
    start_trig();
    wait_run();
    repeat (9) @(posedge clk);
    @(negedge clk) tick = 1'b0;
    expect_res(9, "R4 ticks before window not counted");
    stop(1'b0, 3);

    repeat (4) @(negedge clk);
    check("R6 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule